// File: doc/BRIEF.md
# Segmented ROM-Window Chip-Select Decoder

This block decides, one access at a time, whether a bus-master memory cycle that lands in the legacy add-on ROM window should assert the main-memory chip-select. The window runs from 0C0000h to 0DFFFFh. It is cut into eight fixed 16 KB segments, and each segment carries its own read permission bit and its own write permission bit.

The permission bits are held in two 8-bit attribute registers. A plain configuration port writes them at offsets 54h and 55h and reads them back. Each cycle the requester presents an address, a direction and a valid strobe. The block answers with a registered chip-select one clock later. A global decoder-enable input switches off every chip-select this block could produce, whatever the permission bits hold.

Top module: `romcs_decoder`

## Requirements
- R1: After reset both attribute registers read 00h and `mem_cs` is 0.
- R2: A configuration write with `cfg_addr` equal to 54h or 55h stores `cfg_wdata` in that register. `cfg_rdata` then returns the stored value, combinationally, whenever `cfg_addr` selects that offset.
- R3: A configuration write to any other offset changes neither register. Reads of any other offset return 00h.
- R4: Bit layout. In each register, bit 2k is the read permission and bit 2k+1 is the write permission of segment k (k = 0..3). Register 54h covers segment k at 0C0000h + k*4000h. Register 55h covers segment k at 0D0000h + k*4000h. Each segment is 4000h bytes long.
- R5: A valid read (`acc_write` = 0) inside a segment asserts `mem_cs` only when that segment's read permission bit is 1.
- R6: A valid write (`acc_write` = 1) inside a segment asserts `mem_cs` only when that segment's write permission bit is 1. When both bits are 0, neither direction asserts it.
- R7: While `dec_en` is 0, `mem_cs` is never asserted.
- R8: Addresses below 0C0000h or at or above 0E0000h never assert `mem_cs`.
- R9: `mem_cs` reflects the access presented on the previous clock edge. It is 0 in the cycle after `acc_valid` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (combinational) |
| dec_en | input | 1 | Global decoder enable |
| acc_valid | input | 1 | Access valid strobe |
| acc_addr | input | 24 | Access byte address |
| acc_write | input | 1 | Access direction, 1 = write |
| mem_cs | output | 1 | Registered main-memory chip-select |

## Verification
A corrupted permission bit only shows up when an access hits that segment in the matching direction. The sweep therefore drives every segment with every bit pair, in both directions. A fault then appears on `mem_cs` one clock after the access strobe.

Two other faults are covered the same way. A misplaced register offset shows up at once on `cfg_rdata`. A wrong segment index or window bound misdecodes the first and last byte of each segment, and the boundary bytes just outside the window, again one cycle after the access.

// File: rtl/romcs_pkg.sv
// Shared constants for the ROM-window chip-select decoder.
// Assumes each attribute register holds whole permission pairs.
package romcs_pkg;
    localparam int ATTR_W       = 8;  // width of one attribute register
    localparam int BITS_PER_SEG = 2;  // read + write permission
    localparam int RE_POS       = 0;  // read-permission position inside a pair
    localparam int WE_POS       = 1;  // write-permission position inside a pair
    localparam int SEGS_PER_REG = ATTR_W / BITS_PER_SEG;
endpackage

// File: rtl/romcs_attr_regs.sv
// Attribute register file: NUM_REGS byte registers at consecutive
// configuration offsets from CFG_BASE. Writes go in on the clock edge,
// reads are combinational. Unmatched offsets are ignored and read zero.
// Assumes CFG_BASE + NUM_REGS - 1 fits in CFG_AW bits.
module romcs_attr_regs
    import romcs_pkg::*;
#(
    parameter int CFG_AW   = 8,
    parameter int NUM_REGS = 2,
    parameter int CFG_BASE = 'h54,
    localparam int FLAT_W  = NUM_REGS * ATTR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [ATTR_W-1:0] cfg_wdata,
    output logic [ATTR_W-1:0] cfg_rdata,
    output logic [FLAT_W-1:0] attr_flat
);
    logic [ATTR_W-1:0]   regs_q [NUM_REGS];
    logic [NUM_REGS-1:0] hit;

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        // offset match for register r
        assign hit[r] = (cfg_addr == CFG_AW'(CFG_BASE + r));

        // hold register r, load it on a matching write
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[r] <= '0;
            else if (cfg_we && hit[r])
                regs_q[r] <= cfg_wdata;
        end

        assign attr_flat[r*ATTR_W +: ATTR_W] = regs_q[r];
    end

    // read mux: selected register, or zero for any other offset
    always_comb begin
        cfg_rdata = '0;
        for (int r = 0; r < NUM_REGS; r++)
            if (hit[r]) cfg_rdata = regs_q[r];
    end

    // R1: registers are clear after reset
    a_r1_regs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (attr_flat == '0));

    // R3: a write to an unmapped offset leaves every register unchanged
    a_r3_stray_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (hit == '0)) |=> $stable(attr_flat));

    // R2: a mapped write is visible on the flat view next cycle
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && hit[0]) |=> (attr_flat[ATTR_W-1:0] == $past(cfg_wdata)));
endmodule

// File: rtl/romcs_seg_decode.sv
// Segment decoder: checks whether the address is inside the window
// [WIN_BASE, WIN_BASE + NUM_SEGS*2^SEG_BITS), picks the segment and
// returns its read and write permission bits (zero outside the window).
// Assumes NUM_SEGS is a power of two, at least 2.
module romcs_seg_decode
    import romcs_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int SEG_BITS = 14,
    parameter int NUM_SEGS = 8,
    parameter logic [ADDR_W-1:0] WIN_BASE = 'h0C0000,
    localparam int IDX_W   = $clog2(NUM_SEGS),
    localparam int FLAT_W  = NUM_SEGS * BITS_PER_SEG
) (
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [FLAT_W-1:0] attr_flat,
    output logic              in_win,
    output logic              re_bit,
    output logic              we_bit
);
    localparam logic [ADDR_W-1:0] WIN_SIZE = ADDR_W'(NUM_SEGS) << SEG_BITS;

    logic [ADDR_W-1:0]   offset;
    logic [IDX_W-1:0]    seg_idx;
    logic [NUM_SEGS-1:0] re_vec;
    logic [NUM_SEGS-1:0] we_vec;

    // split the packed attribute pairs into per-segment vectors
    for (genvar s = 0; s < NUM_SEGS; s++) begin : g_seg
        assign re_vec[s] = attr_flat[s*BITS_PER_SEG + RE_POS];
        assign we_vec[s] = attr_flat[s*BITS_PER_SEG + WE_POS];
    end

    // window test and segment selection
    always_comb begin
        offset  = acc_addr - WIN_BASE;
        in_win  = (acc_addr >= WIN_BASE) && (offset < WIN_SIZE);
        seg_idx = offset[SEG_BITS +: IDX_W];
        re_bit  = in_win && re_vec[seg_idx];
        we_bit  = in_win && we_vec[seg_idx];
    end
endmodule

// File: rtl/romcs_cs_gate.sv
// Chip-select gate: combines the strobe, the direction, the global
// enable and the segment permission, then registers the result.
// Assumes the permission bits are already zero outside the window.
module romcs_cs_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic acc_valid,
    input  logic acc_write,
    input  logic dec_en,
    input  logic in_win,
    input  logic re_bit,
    input  logic we_bit,
    output logic mem_cs
);
    logic perm;
    logic cs_d;

    // pick the permission for the access direction, then gate it
    always_comb begin
        perm = acc_write ? we_bit : re_bit;
        cs_d = acc_valid && dec_en && in_win && perm;
    end

    // one-cycle registered chip-select
    always_ff @(posedge clk) begin
        if (!rst_n) mem_cs <= 1'b0;
        else        mem_cs <= cs_d;
    end

    // R7: global enable off means no chip-select
    a_r7_global_off: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(dec_en) |-> !mem_cs);
    // R9: no strobe, no chip-select next cycle
    a_r9_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(acc_valid) |-> !mem_cs);
    // R8: outside the window never selects
    a_r8_outside_window: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!in_win) |-> !mem_cs);
    // R5: a read without read permission never selects
    a_r5_read_perm: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!acc_write && !re_bit) |-> !mem_cs);
    // R6: a write without write permission never selects
    a_r6_write_perm: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc_write && !we_bit) |-> !mem_cs);
endmodule

// File: rtl/romcs_decoder.sv
// Top level: attribute registers, segment decode and chip-select gate
// for the segmented ROM window. Assumes a single clock domain.
module romcs_decoder
    import romcs_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int CFG_AW   = 8,
    parameter int NUM_REGS = 2,
    parameter int CFG_BASE = 'h54,
    parameter int SEG_BITS = 14,
    parameter logic [ADDR_W-1:0] WIN_BASE = 'h0C0000,
    localparam int NUM_SEGS = NUM_REGS * SEGS_PER_REG,
    localparam int FLAT_W   = NUM_REGS * ATTR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [ATTR_W-1:0] cfg_wdata,
    output logic [ATTR_W-1:0] cfg_rdata,
    input  logic              dec_en,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    output logic              mem_cs
);
    logic [FLAT_W-1:0] attr_flat;
    logic              in_win;
    logic              re_bit;
    logic              we_bit;

    romcs_attr_regs #(
        .CFG_AW   (CFG_AW),
        .NUM_REGS (NUM_REGS),
        .CFG_BASE (CFG_BASE)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .attr_flat (attr_flat)
    );

    romcs_seg_decode #(
        .ADDR_W   (ADDR_W),
        .SEG_BITS (SEG_BITS),
        .NUM_SEGS (NUM_SEGS),
        .WIN_BASE (WIN_BASE)
    ) u_dec (
        .acc_addr  (acc_addr),
        .attr_flat (attr_flat),
        .in_win    (in_win),
        .re_bit    (re_bit),
        .we_bit    (we_bit)
    );

    romcs_cs_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .dec_en    (dec_en),
        .in_win    (in_win),
        .re_bit    (re_bit),
        .we_bit    (we_bit),
        .mem_cs    (mem_cs)
    );

    // R1: chip-select is low right after reset
    a_r1_cs_low_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !mem_cs);
endmodule

// File: tb/romcs_decoder_tb.sv
module romcs_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [7:0]  cfg_addr;
    logic [7:0]  cfg_wdata;
    logic [7:0]  cfg_rdata;
    logic        dec_en;
    logic        acc_valid;
    logic [23:0] acc_addr;
    logic        acc_write;
    logic        mem_cs;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [7:0] sh54 = 8'h00;
    logic [7:0] sh55 = 8'h00;

    always #10 clk = ~clk; // 50 MHz

    romcs_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dec_en(dec_en),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_write(acc_write),
        .mem_cs(mem_cs)
    );

    // vector: {r54, r55, en, wr, addr, expected}
    localparam int VW = 43;
    localparam logic [VW-1:0] VEC [10] = '{
        {8'h01, 8'h00, 1'b1, 1'b0, 24'h0C0000, 1'b1},
        {8'h01, 8'h00, 1'b1, 1'b1, 24'h0C0000, 1'b0},
        {8'h02, 8'h00, 1'b1, 1'b1, 24'h0C3FFF, 1'b1},
        {8'h02, 8'h00, 1'b1, 1'b1, 24'h0C4000, 1'b0},
        {8'h00, 8'h80, 1'b1, 1'b1, 24'h0DC000, 1'b1},
        {8'h00, 8'h80, 1'b1, 1'b0, 24'h0DFFFF, 1'b0},
        {8'h00, 8'h40, 1'b1, 1'b0, 24'h0DFFFF, 1'b1},
        {8'hFF, 8'hFF, 1'b0, 1'b0, 24'h0C8000, 1'b0},
        {8'hFF, 8'hFF, 1'b1, 1'b0, 24'h0BFFFF, 1'b0},
        {8'hFF, 8'hFF, 1'b1, 1'b1, 24'h0E0000, 1'b0}
    };

    function automatic logic model_cs(logic [7:0] a, logic [7:0] b,
                                      logic en, logic wr, logic [23:0] ad);
        int seg;
        logic [7:0] rg;
        if (!en || ad < 24'h0C0000 || ad >= 24'h0E0000) return 1'b0;
        seg = int'((ad - 24'h0C0000) >> 14);
        rg  = (seg < 4) ? a : b;
        return rg[(seg % 4) * 2 + int'(wr)];
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(logic [7:0] ad, logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = ad; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (ad == 8'h54) sh54 = d;
        if (ad == 8'h55) sh55 = d;
    endtask

    task automatic cfg_read(string req, logic [7:0] ad, logic [7:0] exp);
        @(negedge clk);
        cfg_addr = ad;
        #1 check(req, cfg_rdata, exp);
    endtask

    // present one access for one cycle; mem_cs is checked after the edge
    task automatic access(string req, logic en, logic wr, logic [23:0] ad);
        @(negedge clk);
        dec_en = en; acc_write = wr; acc_addr = ad; acc_valid = 1'b1;
        @(negedge clk);
        check(req, {7'd0, mem_cs}, {7'd0, model_cs(sh54, sh55, en, wr, ad)});
        acc_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        dec_en = 1'b0; acc_valid = 1'b0; acc_addr = '0; acc_write = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        cfg_read("R1", 8'h54, 8'h00);
        cfg_read("R1", 8'h55, 8'h00);
        check("R1", {7'd0, mem_cs}, 8'h00);

        // table walk: R4/R5/R6/R7/R8
        for (int i = 0; i < 10; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            cfg_write(8'h54, v[42:35]);
            cfg_write(8'h55, v[34:27]);
            @(negedge clk);
            dec_en = v[26]; acc_write = v[25]; acc_addr = v[24:1]; acc_valid = 1'b1;
            @(negedge clk);
            check("R4/R5/R6/R7/R8 vector", {7'd0, mem_cs}, {7'd0, v[0]});
            acc_valid = 1'b0;
        end

        // R2: write and read back
        cfg_write(8'h54, 8'hA5);
        cfg_write(8'h55, 8'h3C);
        cfg_read("R2", 8'h54, 8'hA5);
        cfg_read("R2", 8'h55, 8'h3C);

        // R3: stray offsets ignored and read zero
        cfg_write(8'h53, 8'hFF);
        cfg_write(8'h56, 8'hFF);
        cfg_read("R3", 8'h54, 8'hA5);
        cfg_read("R3", 8'h55, 8'h3C);
        cfg_read("R3", 8'h56, 8'h00);

        // R4/R5/R6/R7 sweep: each segment, each pair value, both directions, enable on/off
        for (int s = 0; s < 8; s++) begin
            for (int c = 0; c < 4; c++) begin
                logic [7:0] val;
                val = 8'(c) << ((s % 4) * 2);
                cfg_write(8'h54, (s < 4) ? val : 8'h00);
                cfg_write(8'h55, (s < 4) ? 8'h00 : val);
                for (int e = 0; e < 2; e++) begin
                    for (int w = 0; w < 2; w++) begin
                        access("R4/R5/R6/R7 sweep first byte", e[0], w[0],
                               24'h0C0000 + 24'(s) * 24'h4000);
                        access("R4/R5/R6/R7 sweep last byte", e[0], w[0],
                               24'h0C3FFF + 24'(s) * 24'h4000);
                    end
                end
            end
        end

        // R8: bytes just outside the window with everything enabled
        cfg_write(8'h54, 8'hFF);
        cfg_write(8'h55, 8'hFF);
        access("R8 below", 1'b1, 1'b0, 24'h0BFFFF);
        access("R8 above", 1'b1, 1'b1, 24'h0E0000);
        access("R8 low edge", 1'b1, 1'b1, 24'h0C0000);
        access("R8 high edge", 1'b1, 1'b0, 24'h0DFFFF);

        // R9: timing of the registered output
        @(negedge clk);
        dec_en = 1'b1; acc_write = 1'b0; acc_addr = 24'h0C8000; acc_valid = 1'b1;
        #1 check("R9 not before edge", {7'd0, mem_cs}, 8'h00);
        @(negedge clk);
        check("R9 one cycle later", {7'd0, mem_cs}, 8'h01);
        acc_valid = 1'b0;
        @(negedge clk);
        check("R9 drops with strobe", {7'd0, mem_cs}, 8'h00);

        // R1: reset again clears registers and output
        @(negedge clk);
        acc_valid = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        acc_valid = 1'b0;
        rst_n = 1'b1;
        check("R1 re-reset cs", {7'd0, mem_cs}, 8'h00);
        sh54 = 8'h00; sh55 = 8'h00;
        cfg_read("R1 re-reset", 8'h54, 8'h00);
        cfg_read("R1 re-reset", 8'h55, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule